// File: doc/BRIEF.md
# Outer-Ring Far Return Unit

This unit carries out a far return that may drop the machine to a less-privileged ring. On a start strobe it captures the current stack selector and stack pointer, the current privilege level, an immediate byte count and an operand-size flag. It then walks the current stack through a single-beat memory read port. It pops the return instruction pointer and then the return code selector. It discards the caller's parameter bytes. If the ring changes, it also pops the outer stack pointer and stack selector.

The privilege level after the return is the low two bits of the popped code selector. A numerically greater level means an outer-ring return: the outer stack pointer and selector are popped from the stack after the parameter bytes are skipped. An equal level means a same-ring return: only the code pointer is popped, and the stack pointer simply advances past the parameter bytes. A numerically smaller level is a protection fault. The fault is reported and nothing is committed.

All results appear together on a registered output bank in the single cycle in which `done` pulses. Validating the popped selectors against descriptors is the job of other logic.

Top module: `far_ret_unit`

## Requirements
- R1: During and after synchronous reset, `done`, `fault` and `mem_rd` are 0 and every result output (`new_cs`, `new_ip`, `new_ss`, `new_sp`, `new_cpl`) is 0.
- R2: After `start`, the first read is at the captured stack pointer and returns the instruction pointer. The second read is at that address plus the pop size and returns the code selector. The pop size is 4 bytes when `op32`=1 and 2 bytes when `op32`=0.
- R3: With `op32`=0, every popped pointer (instruction pointer and outer stack pointer) is the low 16 bits of the read word, zero-extended. With `op32`=1, it is the full 32-bit word.
- R4: A popped selector (code or stack) is always bits 15:0 of its read word, whatever the operand size.
- R5: On an outer-ring return, the outer stack pointer is read at captured SP + 2·pop size + n, and the stack selector is read at that address plus the pop size. `new_sp` and `new_ss` take the popped values.
- R6: On a same-ring return, no further read is made after the selector. `new_ss` equals the captured stack selector, and `new_sp` equals captured SP + 2·pop size + n (modulo 2^32).
- R7: On completion, `new_cpl` equals bits 1:0 of the popped code selector.
- R8: If the popped level is numerically below the current level, `fault` pulses for one cycle with `done` low. No further read is made, and every result output keeps its previous value.
- R9: `done` is a single-cycle pulse, and the result outputs change only in the cycle in which `done` is high.
- R10: `mem_rd` is high for exactly one cycle per read, and no new read is issued until `mem_ack` has returned the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a far return (accepted only when idle) |
| op32 | input | 1 | 1: 32-bit operand size, 0: 16-bit |
| cur_cpl | input | 2 | Current privilege level |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | AW | Current stack pointer |
| imm_n | input | NW | Parameter bytes to discard |
| mem_rd | output | 1 | Read strobe, one cycle per read |
| mem_addr | output | AW | Stack byte offset to read |
| mem_rdata | input | AW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Read data returned |
| done | output | 1 | Results committed this cycle |
| fault | output | 1 | Return to an inner ring was refused |
| new_cs | output | 16 | Committed code selector |
| new_ip | output | AW | Committed instruction pointer |
| new_ss | output | 16 | Committed stack selector |
| new_sp | output | AW | Committed stack pointer |
| new_cpl | output | 2 | Committed privilege level |

## Verification
The bench drives returns to an outer ring, to the same ring and to an inner ring, in both operand sizes. It uses byte counts of zero, small values and 0xFFFF, and a memory latency that varies from return to return.

Every read address is matched against a queue of expected addresses. A unit that skipped the parameter bytes at the wrong point would read the outer stack pointer from the wrong slot. A unit that kept popping on a same-ring return or after a fault would issue an unexpected read.

Results are matched in the done cycle. A wrong operand-size mask would leak the upper half of a 16-bit pop into the result. A fault that committed anything would leave the result outputs different from the previous return's values.

// File: rtl/far_ret_pkg.sv
package far_ret_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } fr_state_t;

  typedef enum logic [1:0] {
    POP_IP,
    POP_CS,
    POP_SP,
    POP_SS
  } fr_pop_t;

  localparam int SEL_W = 16;
  localparam int PL_W  = 2;
endpackage

// File: rtl/far_ret_width.sv
// Operand-size helper: pop step and pointer masking.
module far_ret_width #(
  parameter int AW   = 32,
  parameter int NARW = 16
) (
  input  logic          op32,
  input  logic [AW-1:0] raw,
  output logic [AW-1:0] step,
  output logic [AW-1:0] val
);
  localparam int HI_W = AW - NARW;

  always_comb begin
    step = op32 ? AW'(4) : AW'(2);
    val  = op32 ? raw : {{HI_W{1'b0}}, raw[NARW-1:0]};
  end
endmodule

// File: rtl/far_ret_ring.sv
// Compares the popped requested level with the current one.
module far_ret_ring #(
  parameter int PLW = 2
) (
  input  logic [PLW-1:0] rpl,
  input  logic [PLW-1:0] cpl,
  output logic           outer,
  output logic           inner
);
  always_comb begin
    outer = rpl > cpl;
    inner = rpl < cpl;
  end
endmodule

// File: rtl/far_ret_unit.sv
module far_ret_unit
  import far_ret_pkg::*;
#(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             op32,
  input  logic [1:0]       cur_cpl,
  input  logic [15:0]      cur_ss,
  input  logic [AW-1:0]    cur_sp,
  input  logic [NW-1:0]    imm_n,
  output logic             mem_rd,
  output logic [AW-1:0]    mem_addr,
  input  logic [AW-1:0]    mem_rdata,
  input  logic             mem_ack,
  output logic             done,
  output logic             fault,
  output logic [15:0]      new_cs,
  output logic [AW-1:0]    new_ip,
  output logic [15:0]      new_ss,
  output logic [AW-1:0]    new_sp,
  output logic [1:0]       new_cpl
);
  localparam int NPAD = AW - NW;

  fr_state_t         st_q;
  fr_pop_t           pop_q;
  logic              op32_q;
  logic [PL_W-1:0]   cpl_q;
  logic [SEL_W-1:0]  ss_q;
  logic [SEL_W-1:0]  cs_q;
  logic [NW-1:0]     n_q;
  logic [AW-1:0]     ptr_q;
  logic [AW-1:0]     ip_q;
  logic [AW-1:0]     nsp_q;

  logic [AW-1:0]     step;
  logic [AW-1:0]     pval;
  logic [SEL_W-1:0]  sel;
  logic              is_outer;
  logic              is_inner;
  logic [AW-1:0]     skip_ptr;

  far_ret_width #(.AW(AW), .NARW(16)) u_width (
    .op32 (op32_q),
    .raw  (mem_rdata),
    .step (step),
    .val  (pval)
  );

  assign sel = mem_rdata[SEL_W-1:0];

  far_ret_ring #(.PLW(PL_W)) u_ring (
    .rpl   (sel[PL_W-1:0]),
    .cpl   (cpl_q),
    .outer (is_outer),
    .inner (is_inner)
  );

  // Pointer past the selector slot plus the discarded parameter bytes.
  assign skip_ptr = ptr_q + step + {{NPAD{1'b0}}, n_q};

  assign mem_rd   = (st_q == ST_REQ);
  assign mem_addr = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pop_q   <= POP_IP;
      op32_q  <= 1'b0;
      cpl_q   <= '0;
      ss_q    <= '0;
      cs_q    <= '0;
      n_q     <= '0;
      ptr_q   <= '0;
      ip_q    <= '0;
      nsp_q   <= '0;
      done    <= 1'b0;
      fault   <= 1'b0;
      new_cs  <= '0;
      new_ip  <= '0;
      new_ss  <= '0;
      new_sp  <= '0;
      new_cpl <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            op32_q <= op32;
            cpl_q  <= cur_cpl;
            ss_q   <= cur_ss;
            n_q    <= imm_n;
            ptr_q  <= cur_sp;
            pop_q  <= POP_IP;
            st_q   <= ST_REQ;
          end
        end
        ST_REQ: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_ack) begin
            case (pop_q)
              POP_IP: begin
                ip_q  <= pval;
                ptr_q <= ptr_q + step;
                pop_q <= POP_CS;
                st_q  <= ST_REQ;
              end
              POP_CS: begin
                cs_q <= sel;
                if (is_inner) begin
                  fault <= 1'b1;
                  st_q  <= ST_IDLE;
                end else if (is_outer) begin
                  ptr_q <= skip_ptr;
                  pop_q <= POP_SP;
                  st_q  <= ST_REQ;
                end else begin
                  new_ip  <= ip_q;
                  new_cs  <= sel;
                  new_cpl <= sel[PL_W-1:0];
                  new_ss  <= ss_q;
                  new_sp  <= skip_ptr;
                  done    <= 1'b1;
                  st_q    <= ST_IDLE;
                end
              end
              POP_SP: begin
                nsp_q <= pval;
                ptr_q <= ptr_q + step;
                pop_q <= POP_SS;
                st_q  <= ST_REQ;
              end
              default: begin
                new_ip  <= ip_q;
                new_cs  <= cs_q;
                new_cpl <= cs_q[PL_W-1:0];
                new_ss  <= sel;
                new_sp  <= nsp_q;
                done    <= 1'b1;
                st_q    <= ST_IDLE;
              end
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/far_ret_chk.sv
module far_ret_chk #(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [1:0]    cur_cpl,
  input logic [15:0]   cur_ss,
  input logic          mem_rd,
  input logic          mem_ack,
  input logic          done,
  input logic          fault,
  input logic [15:0]   new_cs,
  input logic [AW-1:0] new_ip,
  input logic [15:0]   new_ss,
  input logic [AW-1:0] new_sp,
  input logic [1:0]    new_cpl
);
  logic        busy_q;
  logic [1:0]  cpl_cap;
  logic [15:0] ss_cap;
  logic        idle_now;

  assign idle_now = !busy_q || done || fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cpl_cap <= '0;
      ss_cap  <= '0;
    end else if (idle_now && start) begin
      busy_q  <= 1'b1;
      cpl_cap <= cur_cpl;
      ss_cap  <= cur_ss;
    end else if (done || fault) begin
      busy_q <= 1'b0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!done && !fault && !mem_rd)) else $error("reset"); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done pulse"); // R9

  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(new_cs) && $stable(new_ip) && $stable(new_ss)
               && $stable(new_sp) && $stable(new_cpl))) else $error("hold"); // R9

  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && fault)) else $error("fault and done"); // R8

  AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    fault |-> !mem_rd) else $error("read after fault"); // R8

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd) else $error("read strobe"); // R10

  AST_LEVEL_FROM_SEL: assert property (@(posedge clk) disable iff (rst)
    done |-> (new_cpl == new_cs[1:0])) else $error("level"); // R7

  AST_NO_INWARD: assert property (@(posedge clk) disable iff (rst)
    (done && busy_q) |-> (new_cpl >= cpl_cap)) else $error("inward"); // R8

  AST_SAME_RING_SS: assert property (@(posedge clk) disable iff (rst)
    (done && busy_q && new_cpl == cpl_cap) |-> (new_ss == ss_cap))
    else $error("same ring ss"); // R6
endmodule

bind far_ret_unit far_ret_chk #(.AW(AW), .NW(NW)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .cur_cpl (cur_cpl),
  .cur_ss  (cur_ss),
  .mem_rd  (mem_rd),
  .mem_ack (mem_ack),
  .done    (done),
  .fault   (fault),
  .new_cs  (new_cs),
  .new_ip  (new_ip),
  .new_ss  (new_ss),
  .new_sp  (new_sp),
  .new_cpl (new_cpl)
);

// File: tb/test_far_ret_unit.sv
`timescale 1ns/1ps
module test_far_ret_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op32 = 1'b0;
  logic [1:0]  cur_cpl = '0;
  logic [15:0] cur_ss = '0;
  logic [31:0] cur_sp = '0;
  logic [15:0] imm_n = '0;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        done, fault;
  logic [15:0] new_cs, new_ss;
  logic [31:0] new_ip, new_sp;
  logic [1:0]  new_cpl;

  always #2.5 clk = ~clk;

  far_ret_unit #(.AW(32), .NW(16)) i_far_ret_unit (
    .clk(clk), .rst(rst), .start(start), .op32(op32), .cur_cpl(cur_cpl),
    .cur_ss(cur_ss), .cur_sp(cur_sp), .imm_n(imm_n), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .done(done), .fault(fault), .new_cs(new_cs), .new_ip(new_ip),
    .new_ss(new_ss), .new_sp(new_sp), .new_cpl(new_cpl)
  );

  typedef struct {
    logic        flt;
    logic [15:0] cs;
    logic [15:0] ss;
    logic [31:0] ip;
    logic [31:0] sp;
    logic [1:0]  cpl;
    string       stag;
  } exp_t;

  exp_t        exq[$];
  logic [31:0] aq[$];
  logic [31:0] mem [0:255];
  int          n_chk = 0;
  int          n_fail = 0;
  int          lat_cfg = 0;
  logic [15:0] last_cs = '0, last_ss = '0;
  logic [31:0] last_ip = '0, last_sp = '0;
  logic [1:0]  last_cpl = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: checks each read address, answers after lat_cfg cycles.
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [31:0] pdata = '0;
  logic        prev_rd = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      pend = 1'b0;
      mem_ack = 1'b0;
      prev_rd = 1'b0;
    end else begin
      mem_ack = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_ack = 1'b1;
          mem_rdata = pdata;
          pend = 1'b0;
        end else cnt--;
      end
      if (mem_rd) begin
        chk("R10 single-cycle read strobe", {63'd0, prev_rd}, 64'd0);
        if (aq.size() == 0) begin
          chk("R6 R8 unexpected read", 64'd1, 64'd0);
        end else begin
          chk("R2 R5 read address", {32'd0, mem_addr}, {32'd0, aq.pop_front()});
        end
        pdata = mem[mem_addr[7:0]];
        pend = 1'b1;
        cnt = lat_cfg;
      end
      prev_rd = mem_rd;
    end
  end

  // Monitor: compare results when the design reports completion.
  always @(negedge clk) begin
    if (!rst && (done || fault)) begin
      if (exq.size() == 0) begin
        chk("R9 unexpected completion", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = exq.pop_front();
        chk("R8 fault flag", {63'd0, fault}, {63'd0, e.flt});
        chk("R8 done flag", {63'd0, done}, {63'd0, !e.flt});
        if (e.flt) begin
          chk("R8 cs held", {48'd0, new_cs}, {48'd0, last_cs});
          chk("R8 ip held", {32'd0, new_ip}, {32'd0, last_ip});
          chk("R8 ss held", {48'd0, new_ss}, {48'd0, last_ss});
          chk("R8 sp held", {32'd0, new_sp}, {32'd0, last_sp});
          chk("R8 cpl held", {62'd0, new_cpl}, {62'd0, last_cpl});
        end else begin
          chk("R3 ip", {32'd0, new_ip}, {32'd0, e.ip});
          chk("R4 cs", {48'd0, new_cs}, {48'd0, e.cs});
          chk("R7 cpl", {62'd0, new_cpl}, {62'd0, e.cpl});
          chk({e.stag, " ss"}, {48'd0, new_ss}, {48'd0, e.ss});
          chk({e.stag, " sp"}, {32'd0, new_sp}, {32'd0, e.sp});
          last_cs = e.cs; last_ip = e.ip; last_ss = e.ss;
          last_sp = e.sp; last_cpl = e.cpl;
        end
      end
    end
  end

  function automatic logic [31:0] msk(input bit o32, input logic [31:0] x);
    return o32 ? x : {16'h0, x[15:0]};
  endfunction

  task automatic do_ret(input bit o32, input logic [1:0] cpl, input logic [15:0] ss,
                        input logic [31:0] sp, input logic [15:0] n,
                        input logic [31:0] w_ip, input logic [31:0] w_cs,
                        input logic [31:0] w_sp, input logic [31:0] w_ss, input int lat);
    exp_t        e;
    logic [31:0] stp, p, a1;
    logic [1:0]  rpl;
    stp = o32 ? 32'd4 : 32'd2;
    a1  = sp + stp;
    rpl = w_cs[1:0];
    mem[sp[7:0]] = w_ip;
    mem[a1[7:0]] = w_cs;
    aq.push_back(sp);
    aq.push_back(a1);
    p = sp + 2 * stp + {16'h0, n};
    e.flt = 1'b0; e.cs = w_cs[15:0]; e.ip = msk(o32, w_ip); e.cpl = rpl;
    e.ss = ss; e.sp = p; e.stag = "R6";
    if (rpl < cpl) begin
      e.flt = 1'b1;
    end else if (rpl > cpl) begin
      mem[p[7:0]] = w_sp;
      a1 = p + stp;
      mem[a1[7:0]] = w_ss;
      aq.push_back(p);
      aq.push_back(a1);
      e.sp = msk(o32, w_sp);
      e.ss = w_ss[15:0];
      e.stag = "R5";
    end
    exq.push_back(e);
    lat_cfg = lat;
    @(negedge clk);
    op32 = o32; cur_cpl = cpl; cur_ss = ss; cur_sp = sp; imm_n = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exq.size() != 0) @(negedge clk);
    @(negedge clk);
    chk("R9 done is one cycle", {62'd0, done, fault}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R6 R8 no further reads", {32'd0, aq.size()}, 64'd0);
    aq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {63'd0, done}, 64'd0);
    chk("R1 rd in reset", {63'd0, mem_rd}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 fault after reset", {63'd0, fault}, 64'd0);
    chk("R1 outputs zero", {new_ip, new_sp}, 64'd0);
    chk("R1 sel zero", {46'd0, new_cs, new_cpl}, {46'd0, 16'd0, 2'd0});
    chk("R1 ss zero", {48'd0, new_ss}, 64'd0);
    // R5 outer ring, 32-bit, n=8
    do_ret(1'b1, 2'd0, 16'h0010, 32'h10, 16'd8, 32'hDEAD_BEEF, 32'h5555_001B,
           32'h8000_1230, 32'hABCD_0023, 0);
    // R3 outer ring, 16-bit, n=4
    do_ret(1'b0, 2'd1, 16'h0020, 32'h40, 16'd4, 32'h1234_5678, 32'hFFFF_0032,
           32'h9999_00F0, 32'h7777_0043, 2);
    // R6 same ring, 32-bit, n=12
    do_ret(1'b1, 2'd2, 16'h0052, 32'h60, 16'd12, 32'h0BAD_F00D, 32'h0000_00A2,
           32'h0, 32'h0, 1);
    // R8 inward return faults
    do_ret(1'b1, 2'd3, 16'h0063, 32'h80, 16'd4, 32'h1111_1111, 32'h2222_0009,
           32'h0, 32'h0, 3);
    // R5 outer ring, 16-bit, n=0
    do_ret(1'b0, 2'd0, 16'h0008, 32'hA0, 16'd0, 32'hCAFE_0100, 32'h1234_0073,
           32'hFEDC_FFFE, 32'h4321_0083, 0);
    // R6 same ring, 16-bit, n=0
    do_ret(1'b0, 2'd3, 16'h0093, 32'hC0, 16'd0, 32'hAAAA_2468, 32'hBBBB_00CB,
           32'h0, 32'h0, 1);
    // R6 same ring, 32-bit, largest n
    do_ret(1'b1, 2'd1, 16'h0019, 32'h20, 16'hFFFF, 32'h0000_4000, 32'h0000_0101,
           32'h0, 32'h0, 2);
    // R8 fault from ring 2 to ring 0, 16-bit
    do_ret(1'b0, 2'd2, 16'h0012, 32'hE0, 16'd2, 32'h3333_3333, 32'h4444_0010,
           32'h0, 32'h0, 0);
    // R7 outer ring 1 to 2, 32-bit, long latency
    do_ret(1'b1, 2'd1, 16'h0031, 32'h30, 16'd16, 32'h0040_0000, 32'h0000_02BE,
           32'h0012_3400, 32'hFFFF_00B2, 3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule